// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Core with Lane Writes

This block is a single-port synchronous RAM whose 36-bit word is split into four 9-bit lanes. Every control and data input is captured on the rising clock edge into an input stage. Read data leaves through an output register, so a read captured at one edge is visible after the following edge. A small two-bit burst sequencer lets a host start an access with one of two address strobes and then step through up to four neighbouring words. The low address bits are generated inside the block, in either linear or exclusive-or order.

A write can cover any subset of the four lanes. The per-lane enables take effect only while the lane-write qualifier is low. A separate all-lane write input overrides both and writes the whole word. The output driver enable is held for one extra cycle after a deselect, so that several devices can share a data bus without wait states. An asynchronous output-enable input masks the driver enable combinationally.

Top module: `sram_pipe_core`

## Requirements
- R1: During and after a synchronous active-low reset, with no access started, `drive_en` is 0 and `rdata` is all zeros.
- R2: A read captured at clock edge N shows its word on `rdata`, with `drive_en` high, after edge N+1. `rdata` keeps its value in every cycle without a read.
- R3: When `wr_all_n` is low on an access that may write, all four lanes are written, whatever `wr_lanes_n` and `lane_en_n` hold.
- R4: With `wr_all_n` high and `wr_lanes_n` low, only lane i with `lane_en_n[i]` low is written. Lane i occupies `wdata`/`rdata` bits 9i+8 down to 9i. The other lanes keep their contents.
- R5: With `wr_all_n` high and `wr_lanes_n` high, an access is a read and memory is unchanged.
- R6: A strobe selects the device only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Any other combination deselects it: no access and no write.
- R7: A read of an address in the cycle right after a write to it returns the newly written data.
- R8: After a read, the first cycle with no access still drives (`drive_en` high, `rdata` held). The following cycle does not drive. A write cycle never drives.
- R9: `out_en_n` high forces `drive_en` low at once, without waiting for a clock edge.
- R10: An access started with `strb_host_n` low is always a read, even if write controls are active. `strb_host_n` takes precedence over `strb_ctl_n`.
- R11: With `burst_xor`=0, each cycle with no strobe and `step_n` low after a started access advances the two low address bits as (start + k) mod 4. Such cycles may write.
- R12: With `burst_xor`=1, the k-th advance addresses low bits start XOR k. The upper address bits stay those of the start.
- R13: A cycle with no strobe and `step_n` high after a started access repeats the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 6 | Word address, taken on a selecting strobe |
| strb_host_n | input | 1 | Host address strobe, active low, starts a read |
| strb_ctl_n | input | 1 | Controller address strobe, active low, starts a read or write |
| step_n | input | 1 | Active-low burst advance |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Active-low write of all lanes |
| wr_lanes_n | input | 1 | Active-low qualifier for per-lane writes |
| lane_en_n | input | 4 | Active-low per-lane write enables |
| wdata | input | 36 | Write data, four 9-bit lanes |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| burst_xor | input | 1 | Burst order: 0 linear, 1 exclusive-or |
| rdata | output | 36 | Output register contents |
| drive_en | output | 1 | Output driver enable |

## Verification
The embedded properties assume a well-formed command stream: chip selects and write controls are stable around each rising edge. `burst_xor` changes only while no burst is running, so the linear-step property never spans a mode change. The stimulus drives inputs only at falling edges. It switches the burst order only after a deselect, and it reads only addresses that have already been written, so every sampled word is defined. The asynchronous output enable is toggled only inside the middle of a cycle and restored before the next edge. The clocked driver properties therefore see it inactive, except where the output-enable property checks it.

// File: rtl/sram_pipe_pkg.sv
// Shared constants and the cycle classification used by the SRAM core.
// Assumes four lanes of nine bits and a two-bit burst sequence by default.
package sram_pipe_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int BURST_W = 2;
    localparam int ADDR_W  = 6;

    // Kind of cycle decoded from the strobes, selects and advance input.
    typedef enum logic [2:0] {
        CY_IDLE,
        CY_DESEL,
        CY_START_RD,
        CY_START_ACC,
        CY_ADVANCE,
        CY_SUSPEND
    } cyc_kind_e;
endpackage

// File: rtl/sram_burst_seq.sv
// Burst address generator: combines the captured start address with the
// burst step, in linear or exclusive-or order on the low BURST_W bits.
// Assumes ADDR_W >= BURST_W; the upper bits are taken from the start.
module sram_burst_seq #(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [BURST_W-1:0] step,
    input  logic               use_xor,
    output logic [ADDR_W-1:0]  addr
);
    logic [BURST_W-1:0] low_lin;
    logic [BURST_W-1:0] low_xor;
    logic [BURST_W-1:0] low_sel;

    // Both burst orders on the low bits, then pick one.
    always_comb begin
        low_lin = base[BURST_W-1:0] + step;
        low_xor = base[BURST_W-1:0] ^ step;
        low_sel = use_xor ? low_xor : low_lin;
    end

    generate
        if (ADDR_W > BURST_W) begin : g_upper
            // Upper bits stay fixed for the whole burst.
            assign addr = {base[ADDR_W-1:BURST_W], low_sel};
        end else begin : g_only_low
            // Whole address is the burst field.
            assign addr = low_sel;
        end
    endgenerate
endmodule

// File: rtl/sram_cmd_reg.sv
// Input stage: decodes strobes, selects and advance into a cycle kind,
// qualifies the lane writes, and registers the access for the array.
// Assumes inputs are stable around the rising edge; reset is synchronous.
module sram_cmd_reg
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strb_host_n,
    input  logic              strb_ctl_n,
    input  logic              step_n,
    input  logic              cs_a_n,
    input  logic              cs_b,
    input  logic              cs_c_n,
    input  logic              wr_all_n,
    input  logic              wr_lanes_n,
    input  logic [LANES-1:0]  lane_en_n,
    input  logic [WORD_W-1:0] wdata,
    input  logic              burst_xor,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  acc_wmask,
    output logic [WORD_W-1:0] acc_wdata
);
    cyc_kind_e          kind;
    logic               start;
    logic               chosen;
    logic               may_write;
    logic               act_q;
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] step_q;
    logic [ADDR_W-1:0]  base_nx;
    logic [BURST_W-1:0] step_nx;
    logic [ADDR_W-1:0]  seq_addr;
    logic [LANES-1:0]   lane_req;

    // Classify the current cycle from the control inputs.
    always_comb begin
        start  = !strb_host_n || !strb_ctl_n;
        chosen = !cs_a_n && cs_b && !cs_c_n;
        if (start) begin
            if (!chosen)          kind = CY_DESEL;
            else if (!strb_host_n) kind = CY_START_RD;
            else                   kind = CY_START_ACC;
        end else if (act_q) begin
            kind = step_n ? CY_SUSPEND : CY_ADVANCE;
        end else begin
            kind = CY_IDLE;
        end
        may_write = (kind == CY_START_ACC) || (kind == CY_ADVANCE) ||
                    (kind == CY_SUSPEND);
    end

    // Per-lane write request: all-lane write, or qualified lane enable.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane_req
            assign lane_req[g] = !wr_all_n || (!wr_lanes_n && !lane_en_n[g]);
        end
    endgenerate

    // Next burst start and step for this cycle.
    always_comb begin
        base_nx = base_q;
        step_nx = step_q;
        if (kind == CY_START_RD || kind == CY_START_ACC) begin
            base_nx = addr;
            step_nx = '0;
        end else if (kind == CY_ADVANCE) begin
            step_nx = step_q + 1'b1;
        end
    end

    sram_burst_seq #(
        .ADDR_W (ADDR_W),
        .BURST_W(BURST_W)
    ) u_seq (
        .base   (base_nx),
        .step   (step_nx),
        .use_xor(burst_xor),
        .addr   (seq_addr)
    );

    // Register the decoded access and the burst state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= 1'b0;
            base_q    <= '0;
            step_q    <= '0;
            acc_addr  <= '0;
            acc_wmask <= '0;
            acc_wdata <= '0;
        end else begin
            if (kind == CY_START_RD || kind == CY_START_ACC) act_q <= 1'b1;
            else if (kind == CY_DESEL)                        act_q <= 1'b0;
            base_q    <= base_nx;
            step_q    <= step_nx;
            acc_addr  <= seq_addr;
            acc_wmask <= may_write ? lane_req : '0;
            acc_wdata <= wdata;
        end
    end

    assign acc_valid = act_q;

    a_r6_desel_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !chosen) |=> (!acc_valid && acc_wmask == '0));

    a_r10_host_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_host_n && chosen) |=> (acc_valid && acc_wmask == '0));

    a_r3_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (may_write && !wr_all_n) |=> (&acc_wmask));

    a_r13_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CY_SUSPEND) |=> $stable(acc_addr));

    a_r11_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CY_ADVANCE && !burst_xor) |=>
        (acc_addr[BURST_W-1:0] == BURST_W'($past(acc_addr[BURST_W-1:0]) + 1'b1)));
endmodule

// File: rtl/sram_lane_array.sv
// Storage split into lanes, each with its own write enable, plus the
// registered read output. Writes land at the edge that ends the access cycle,
// so a read captured at that same edge sees the new data one cycle later.
// Assumes the mask is zero whenever no access is valid.
module sram_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_rd,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LANES-1:0]  acc_wmask,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic [WORD_W-1:0] rdata
);
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];
            logic [LANE_W-1:0] rd_q;

            // Lane write when its mask bit is set.
            always_ff @(posedge clk) begin
                if (acc_valid && acc_wmask[g])
                    mem[acc_addr] <= acc_wdata[g*LANE_W +: LANE_W];
            end

            // Lane output register, loaded only by a read.
            always_ff @(posedge clk) begin
                if (!rst_n)      rd_q <= '0;
                else if (acc_rd) rd_q <= mem[acc_addr];
            end

            assign rdata[g*LANE_W +: LANE_W] = rd_q;
        end
    endgenerate

    a_r2_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> $stable(rdata));
endmodule

// File: rtl/sram_drive_pipe.sv
// Output driver enable with one extra cycle after a deselect or idle cycle
// that follows a read, then masked by the asynchronous output enable.
// Assumes acc_rd implies acc_valid.
module sram_drive_pipe (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_valid,
    input  logic acc_rd,
    input  logic out_en_n,
    output logic drive_en
);
    logic drv_main;
    logic drv_ext;

    // Main enable follows reads; extension covers one cycle without access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_main <= 1'b0;
            drv_ext  <= 1'b0;
        end else begin
            drv_main <= acc_rd;
            drv_ext  <= drv_main && !acc_valid;
        end
    end

    assign drive_en = (drv_main || drv_ext) && !out_en_n;

    a_r8_extension_single: assert property (@(posedge clk) disable iff (!rst_n)
        drv_ext |=> !drv_ext);

    a_r8_write_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_rd) |=> !drive_en);

    a_r9_oe_masks: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !drive_en);
endmodule

// File: rtl/sram_pipe_core.sv
// Top of the pipelined SRAM core: input stage, lane storage with output
// register, and the driver enable pipeline.
// Assumes synchronous active-low reset and a single clock.
module sram_pipe_core
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W  = sram_pipe_pkg::ADDR_W,
    parameter int LANES   = sram_pipe_pkg::LANES,
    parameter int LANE_W  = sram_pipe_pkg::LANE_W,
    parameter int BURST_W = sram_pipe_pkg::BURST_W,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strb_host_n,
    input  logic              strb_ctl_n,
    input  logic              step_n,
    input  logic              cs_a_n,
    input  logic              cs_b,
    input  logic              cs_c_n,
    input  logic              wr_all_n,
    input  logic              wr_lanes_n,
    input  logic [LANES-1:0]  lane_en_n,
    input  logic [WORD_W-1:0] wdata,
    input  logic              out_en_n,
    input  logic              burst_xor,
    output logic [WORD_W-1:0] rdata,
    output logic              drive_en
);
    logic              acc_valid;
    logic              acc_rd;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  acc_wmask;
    logic [WORD_W-1:0] acc_wdata;

    sram_cmd_reg #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .BURST_W(BURST_W)
    ) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .strb_host_n(strb_host_n),
        .strb_ctl_n (strb_ctl_n),
        .step_n     (step_n),
        .cs_a_n     (cs_a_n),
        .cs_b       (cs_b),
        .cs_c_n     (cs_c_n),
        .wr_all_n   (wr_all_n),
        .wr_lanes_n (wr_lanes_n),
        .lane_en_n  (lane_en_n),
        .wdata      (wdata),
        .burst_xor  (burst_xor),
        .acc_valid  (acc_valid),
        .acc_addr   (acc_addr),
        .acc_wmask  (acc_wmask),
        .acc_wdata  (acc_wdata)
    );

    // A valid access with no lane written is a read.
    assign acc_rd = acc_valid && (acc_wmask == '0);

    sram_lane_array #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_valid(acc_valid),
        .acc_rd   (acc_rd),
        .acc_addr (acc_addr),
        .acc_wmask(acc_wmask),
        .acc_wdata(acc_wdata),
        .rdata    (rdata)
    );

    sram_drive_pipe u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_valid(acc_valid),
        .acc_rd   (acc_rd),
        .out_en_n (out_en_n),
        .drive_en (drive_en)
    );
endmodule

// File: tb/sram_pipe_core_test.sv
`timescale 1ns/1ps
module sram_pipe_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        strb_host_n = 1'b1, strb_ctl_n = 1'b1, step_n = 1'b1;
    logic        cs_a_n = 1'b0, cs_b = 1'b1, cs_c_n = 1'b0;
    logic        wr_all_n = 1'b1, wr_lanes_n = 1'b1;
    logic [3:0]  lane_en_n = 4'hF;
    logic [35:0] wdata = '0;
    logic        out_en_n = 1'b0, burst_xor = 1'b0;
    logic [35:0] rdata;
    logic        drive_en;

    sram_pipe_core uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strb_host_n(strb_host_n),
        .strb_ctl_n(strb_ctl_n), .step_n(step_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
        .cs_c_n(cs_c_n), .wr_all_n(wr_all_n), .wr_lanes_n(wr_lanes_n),
        .lane_en_n(lane_en_n), .wdata(wdata), .out_en_n(out_en_n),
        .burst_xor(burst_xor), .rdata(rdata), .drive_en(drive_en)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Scoreboard queues.
    int          q_due[$];
    bit          q_en[$];
    logic [35:0] q_d[$];
    string       q_tag[$];

    // Reference state.
    logic [35:0] mm [64];
    bit          m_act = 0, m_main = 0;
    int          m_base = 0, m_step = 0;
    logic [35:0] m_held = '0;

    task automatic check(input bit ok, input string tag, input logic [35:0] act,
                         input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] pat(input int a);
        return {4{9'(a * 37 + 11)}} ^ 36'hA5A5A5A5A;
    endfunction

    // Driver: apply one cycle of inputs and push the expected result.
    task automatic issue(input bit sp, input bit sc, input bit stp, input bit s1,
                         input bit s2, input bit s3, input bit wa, input bit wl,
                         input logic [3:0] le, input int a, input logic [35:0] wd,
                         input string tag);
        bit start, chosen, acc, wok, is_rd;
        int cur;
        logic [3:0] mask;
        @(negedge clk);
        strb_host_n = sp; strb_ctl_n = sc; step_n = stp;
        cs_a_n = s1; cs_b = s2; cs_c_n = s3;
        wr_all_n = wa; wr_lanes_n = wl; lane_en_n = le;
        addr = 6'(a); wdata = wd;
        start = !sp || !sc; chosen = !s1 && s2 && !s3;
        acc = 0; wok = 0;
        if (start) begin
            if (chosen) begin
                m_act = 1; m_base = a; m_step = 0; acc = 1; wok = sp;
            end else m_act = 0;
        end else if (m_act) begin
            acc = 1; wok = 1;
            if (!stp) m_step = (m_step + 1) % 4;
        end
        cur = (m_base & ~3) | (burst_xor ? ((m_base & 3) ^ m_step)
                                         : (((m_base & 3) + m_step) & 3));
        for (int i = 0; i < 4; i++) mask[i] = acc && wok && (!wa || (!wl && !le[i]));
        is_rd = acc && (mask == 4'h0);
        for (int i = 0; i < 4; i++)
            if (mask[i]) mm[cur][i*9 +: 9] = wd[i*9 +: 9];
        q_due.push_back(cyc + 2);
        q_tag.push_back(tag);
        if (is_rd) begin
            m_held = mm[cur];
            q_en.push_back(1'b1);
        end else q_en.push_back(!acc && m_main);
        q_d.push_back(m_held);
        m_main = is_rd;
    endtask

    task automatic wr_all(input int a, input logic [35:0] d, input string tag);
        issue(1, 0, 1, 0, 1, 0, 0, 1, 4'hF, a, d, tag);
    endtask
    task automatic rd_h(input int a, input string tag);
        issue(0, 1, 1, 0, 1, 0, 1, 1, 4'hF, a, '0, tag);
    endtask
    task automatic idle(input string tag);
        issue(1, 1, 1, 0, 1, 0, 1, 1, 4'hF, 0, '0, tag);
    endtask
    task automatic desel(input string tag);
        issue(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, 0, '0, tag);
    endtask
    task automatic adv(input string tag);
        issue(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 0, '0, tag);
    endtask
    task automatic susp(input string tag);
        issue(1, 1, 1, 0, 1, 0, 1, 1, 4'hF, 0, '0, tag);
    endtask

    // Monitor: compare outputs in the cycle each result is due.
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] == cyc) begin
            check(drive_en == q_en[0], {q_tag[0], " drive"}, 36'(drive_en), 36'(q_en[0]));
            if (q_en[0])
                check(rdata == q_d[0], {q_tag[0], " data"}, rdata, q_d[0]);
            void'(q_due.pop_front()); void'(q_en.pop_front());
            void'(q_d.pop_front());   void'(q_tag.pop_front());
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(drive_en == 1'b0, "R1 drive", 36'(drive_en), 36'h0);
        check(rdata == '0, "R1 data", rdata, 36'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(drive_en == 1'b0 && rdata == '0, "R1 after release", rdata, 36'h0);

        // R3: all-lane write ignores the lane enables (left inactive).
        for (int a = 0; a < 12; a++) wr_all(a, pat(a), "R3");
        for (int a = 0; a < 8; a++) rd_h(a, "R2 R3");
        idle("R8"); idle("R8");

        // R4: lane write to lanes 0 and 3 only.
        issue(1, 0, 1, 0, 1, 0, 1, 0, 4'b0110, 3, 36'hFFFFFFFFF, "R4");
        idle("R4");
        rd_h(3, "R4");
        // R7: read right after write.
        issue(1, 0, 1, 0, 1, 0, 1, 0, 4'b1010, 5, 36'h123456789, "R7");
        rd_h(5, "R7");

        // R5: unqualified lane enables give a read.
        issue(1, 0, 1, 0, 1, 0, 1, 1, 4'h0, 1, 36'h0, "R5");
        rd_h(1, "R5");

        // R10: host strobe with write controls active still reads.
        issue(0, 1, 1, 0, 1, 0, 0, 0, 4'h0, 2, 36'h0, "R10");
        rd_h(2, "R10");

        // R6: each non-selecting combination blocks the write.
        issue(1, 0, 1, 1, 1, 0, 0, 1, 4'hF, 4, 36'h0, "R6");
        issue(1, 0, 1, 0, 0, 0, 0, 1, 4'hF, 4, 36'h0, "R6");
        issue(1, 0, 1, 0, 1, 1, 0, 1, 4'hF, 4, 36'h0, "R6");
        rd_h(4, "R6");

        // R8: read, then two deselects, then a write after a read.
        rd_h(6, "R8"); desel("R8"); desel("R8"); idle("R8");
        rd_h(7, "R8"); wr_all(7, pat(7), "R8"); idle("R8");

        // R11: linear burst from 5.
        rd_h(5, "R11"); adv("R11"); adv("R11"); adv("R11"); adv("R11");
        desel("R11");
        // R11: burst write then read back.
        wr_all(8, pat(40), "R11");
        issue(1, 1, 0, 0, 1, 0, 0, 1, 4'hF, 0, pat(41), "R11");
        issue(1, 1, 0, 0, 1, 0, 0, 1, 4'hF, 0, pat(42), "R11");
        rd_h(9, "R11"); rd_h(10, "R11"); desel("R11");

        // R12: exclusive-or burst from 5.
        burst_xor = 1'b1;
        rd_h(5, "R12"); adv("R12"); adv("R12"); adv("R12");
        // R13: suspend repeats the address.
        rd_h(2, "R13"); susp("R13"); susp("R13"); adv("R13");
        desel("R13");
        burst_xor = 1'b0;
        idle("R13");

        // R9: asynchronous output enable masks a driven cycle.
        rd_h(7, "R9");
        fork
            begin
                @(posedge clk); @(posedge clk);
                #1 out_en_n = 1'b1;
                #0.5 check(drive_en == 1'b0, "R9 oe mask", 36'(drive_en), 36'h0);
                #0.5 out_en_n = 1'b0;
            end
        join_none
        idle("R9"); idle("R9"); idle("R9");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 36'h0, 36'h1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule